// File: doc/BRIEF.md
# Dual-port PS/2 host controller

This block is the host-side register front end for a keyboard port and an auxiliary (pointing device) port. Software sees two byte-wide addresses: a data address and a command/status address. Bytes delivered by each device side land in a per-port receive queue. A single output buffer holds one byte at a time, tagged with the port or the controller itself as its source. When the buffer is empty it is refilled from the keyboard queue first, and from the auxiliary queue only when no keyboard byte waits. Per-port interrupt lines rise when a device byte enters the buffer, provided the configuration byte enables them.

Writes to the command address select controller operations: reading or loading the configuration byte, enabling or disabling either port, self-test replies, reading or loading the output port, injecting a byte as if it came from either device, forwarding a byte to the auxiliary device, and requesting a system reset. A write to the data address that follows no argument-taking command is forwarded to the keyboard device as a one-cycle strobe.

Top module: `ps2h_ctrl`

## Requirements
- R1: After reset the configuration byte is 0x74, the output port is 0x01, both interrupt lines are low and the status byte reads 0x14.
- R2: Status byte layout: bit 0 is output-buffer full, bit 2 copies configuration bit 2, bit 3 is set by a command-address write and cleared by a data-address write, bit 4 is always 1, bit 5 is set while the buffered byte came from the auxiliary port, bits 7, 6 and 1 are 0.
- R3: Command 0x20 places the configuration byte in the buffer; command 0x60 makes the next data write load the configuration byte. Controller replies raise no interrupt. Any other command issued in between cancels the pending load.
- R4: Commands 0xAD/0xAE set/clear configuration bit 4 (keyboard off) and 0xA7/0xA8 set/clear configuration bit 5 (auxiliary off).
- R5: Self-test replies: 0xAA gives 0x55, 0xA9 and 0xAB give 0x00, 0xA1 gives 0xF1.
- R6: Command 0xD0 places the output port in the buffer; command 0xD1 makes the next data write load the output port, and the keyboard and auxiliary interrupt lines take that byte's bits 4 and 5.
- R7: Commands 0xD2 and 0xD3 make the next data byte enter the buffer tagged as keyboard or auxiliary data, with the same interrupt gating as a received byte.
- R8: Command 0xD4 forwards the next data byte on the auxiliary transmit strobe; a data write with nothing pending goes out on the keyboard transmit strobe. Each strobe lasts one cycle.
- R9: A keyboard byte entering the buffer raises the keyboard interrupt when configuration bit 0 is set; an auxiliary byte raises the auxiliary interrupt when configuration bit 1 is set. Output port bits 4 and 5 always equal the keyboard and auxiliary interrupt lines.
- R10: Reading the data address returns the buffered byte and clears buffer full, status bit 5 and both interrupts; reading it while empty returns 0x00.
- R11: An empty buffer refills one cycle later from the keyboard queue, or from the auxiliary queue only if the keyboard queue is empty; a port disabled in the configuration is skipped and its bytes stay queued.
- R12: Even commands 0xF0 to 0xFE each give a one-cycle system reset pulse; odd commands 0xF1 to 0xFF change nothing.
- R13: Each receive queue holds FIFO_DEPTH bytes in arrival order and drops its ready output when full.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe (side effects apply at the clock edge) |
| host_addr | input | 1 | 0 selects data, 1 selects command/status |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Read byte for the current address |
| kbd_in_valid | input | 1 | Keyboard device byte offered |
| kbd_in_data | input | 8 | Keyboard device byte |
| kbd_in_ready | output | 1 | Keyboard queue has room |
| aux_in_valid | input | 1 | Auxiliary device byte offered |
| aux_in_data | input | 8 | Auxiliary device byte |
| aux_in_ready | output | 1 | Auxiliary queue has room |
| kbd_tx_valid | output | 1 | One-cycle strobe of a byte for the keyboard |
| kbd_tx_data | output | 8 | Byte for the keyboard |
| aux_tx_valid | output | 1 | One-cycle strobe of a byte for the auxiliary device |
| aux_tx_data | output | 8 | Byte for the auxiliary device |
| irq_kbd | output | 1 | Keyboard interrupt line |
| irq_aux | output | 1 | Auxiliary interrupt line |
| outport | output | 8 | Controller output port |
| sys_reset_req | output | 1 | One-cycle system reset request |

## Verification
The bench builds the controller with its default queue depth of 64, so a full keyboard queue is reached by 64 pushes while the port is disabled, which brings the ready drop and the drain order of a complete queue within reach. Both ports start disabled after reset, which exercises skipping of queued bytes before any configuration write. Priority between the ports is checked by queueing one byte on each while a controller reply occupies the buffer.

// File: rtl/ps2h_pkg.sv
// Shared constants and types for the dual-port PS/2 host controller.
// Assumes byte-wide registers throughout.
package ps2h_pkg;

    localparam int BYTE_W = 8;

    // Reset values
    localparam logic [BYTE_W-1:0] CFG_RST   = 8'h74;
    localparam logic [BYTE_W-1:0] OPORT_RST = 8'h01;

    // Configuration bit positions
    localparam int CFG_KBD_IRQ = 0;
    localparam int CFG_AUX_IRQ = 1;
    localparam int CFG_SYS     = 2;
    localparam int CFG_KBD_OFF = 4;
    localparam int CFG_AUX_OFF = 5;

    // Output port bits mirroring the interrupt lines
    localparam int OP_KBD_IRQ = 4;
    localparam int OP_AUX_IRQ = 5;

    // Status bit positions
    localparam int ST_FULL  = 0;
    localparam int ST_SYS   = 2;
    localparam int ST_CMD   = 3;
    localparam int ST_UNLCK = 4;
    localparam int ST_AUX   = 5;

    // Receive port indices; lower index wins refill
    localparam int PORT_KBD = 0;
    localparam int PORT_AUX = 1;
    localparam int NPORT    = 2;

    // Argument awaited by the next data write
    typedef enum logic [2:0] {
        PEND_NONE,
        PEND_CFG,
        PEND_OPORT,
        PEND_KBD_INJ,
        PEND_AUX_INJ,
        PEND_AUX_TX
    } pend_t;

    // Origin of the byte in the output buffer
    typedef enum logic [1:0] {
        SRC_CTRL,
        SRC_KBD,
        SRC_AUX
    } src_t;

    // Decoded effect of one command byte
    typedef struct packed {
        logic              resp_en;
        logic [BYTE_W-1:0] resp_byte;
        logic [BYTE_W-1:0] cfg_set;
        logic [BYTE_W-1:0] cfg_clr;
        pend_t             pend;
        logic              reset_pulse;
    } cmd_dec_t;

endpackage

// File: rtl/ps2h_rx_fifo.sv
// Receive queue for one device port: DEPTH bytes, valid/ready on both
// sides, first in first out. Assumes DEPTH >= 2. Data storage has no reset.
module ps2h_rx_fifo #(
    parameter int DW    = 8,
    parameter int DEPTH = 64
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic [DW-1:0] in_data,
    output logic          in_ready,
    output logic          out_valid,
    output logic [DW-1:0] out_data,
    input  logic          out_ready
);

    localparam int AW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] wr_ptr;
    logic [AW-1:0] rd_ptr;
    logic [CW-1:0] count;
    logic          push;
    logic          pop;

    assign in_ready  = (count != CW'(DEPTH));
    assign out_valid = (count != '0);
    assign out_data  = mem[rd_ptr];
    assign push      = in_valid && in_ready;
    assign pop       = out_valid && out_ready;

    // Store an accepted byte.
    always_ff @(posedge clk) begin
        if (push) begin
            mem[wr_ptr] <= in_data;
        end
    end

    // Advance pointers and occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) begin
                wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
            end
            if (pop) begin
                rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
            end
            case ({push, pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

endmodule

// File: rtl/ps2h_refill_arb.sv
// Picks which receive queue refills the empty output buffer: the lowest
// index that has a byte and is not disabled. Nothing is picked while the
// host accesses the controller in the same cycle.
module ps2h_refill_arb #(
    parameter int NSRC = 2
) (
    input  logic            buf_empty,
    input  logic            hold,
    input  logic [NSRC-1:0] src_valid,
    input  logic [NSRC-1:0] src_off,
    output logic [NSRC-1:0] pop
);

    logic taken;

    // Fixed-priority one-hot selection.
    always_comb begin
        pop   = '0;
        taken = 1'b0;
        for (int i = 0; i < NSRC; i++) begin
            if (!taken && buf_empty && !hold && src_valid[i] && !src_off[i]) begin
                pop[i] = 1'b1;
                taken  = 1'b1;
            end
        end
    end

endmodule

// File: rtl/ps2h_cmd_decode.sv
// Decodes a byte written to the command address into its effects:
// an immediate reply, configuration bit changes, an awaited argument or a
// reset pulse. Purely combinational; unknown codes have no effect.
module ps2h_cmd_decode
    import ps2h_pkg::*;
(
    input  logic [BYTE_W-1:0] cmd,
    input  logic [BYTE_W-1:0] cfg,
    input  logic [BYTE_W-1:0] oport,
    output cmd_dec_t          dec
);

    localparam logic [BYTE_W-1:0] BIT_KBD_OFF = BYTE_W'(1) << CFG_KBD_OFF;
    localparam logic [BYTE_W-1:0] BIT_AUX_OFF = BYTE_W'(1) << CFG_AUX_OFF;

    // Command byte to effect.
    always_comb begin
        dec = '{resp_en: 1'b0, resp_byte: '0, cfg_set: '0, cfg_clr: '0,
                pend: PEND_NONE, reset_pulse: 1'b0};
        case (cmd)
            8'h20: begin dec.resp_en = 1'b1; dec.resp_byte = cfg;   end
            8'hD0: begin dec.resp_en = 1'b1; dec.resp_byte = oport; end
            8'hAA: begin dec.resp_en = 1'b1; dec.resp_byte = 8'h55; end
            8'hA9,
            8'hAB: begin dec.resp_en = 1'b1; dec.resp_byte = 8'h00; end
            8'hA1: begin dec.resp_en = 1'b1; dec.resp_byte = 8'hF1; end
            8'hAD: dec.cfg_set = BIT_KBD_OFF;
            8'hAE: dec.cfg_clr = BIT_KBD_OFF;
            8'hA7: dec.cfg_set = BIT_AUX_OFF;
            8'hA8: dec.cfg_clr = BIT_AUX_OFF;
            8'h60: dec.pend = PEND_CFG;
            8'hD1: dec.pend = PEND_OPORT;
            8'hD2: dec.pend = PEND_KBD_INJ;
            8'hD3: dec.pend = PEND_AUX_INJ;
            8'hD4: dec.pend = PEND_AUX_TX;
            default: begin
                if (cmd[7:4] == 4'hF && !cmd[0]) begin
                    dec.reset_pulse = 1'b1;
                end
            end
        endcase
    end

endmodule

// File: rtl/ps2h_ctrl.sv
// Dual-port PS/2 host controller top. Holds the configuration byte, the
// output port, the one-byte output buffer with its source tag, the command
// flag and the awaited-argument state. Two receive queues feed the buffer.
// Assumes host_wr and host_rd are never high in the same cycle; a read's
// side effects take place at the clock edge that ends the strobe.
module ps2h_ctrl
    import ps2h_pkg::*;
#(
    parameter int FIFO_DEPTH = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_wr,
    input  logic              host_rd,
    input  logic              host_addr,
    input  logic [BYTE_W-1:0] host_wdata,
    output logic [BYTE_W-1:0] host_rdata,
    input  logic              kbd_in_valid,
    input  logic [BYTE_W-1:0] kbd_in_data,
    output logic              kbd_in_ready,
    input  logic              aux_in_valid,
    input  logic [BYTE_W-1:0] aux_in_data,
    output logic              aux_in_ready,
    output logic              kbd_tx_valid,
    output logic [BYTE_W-1:0] kbd_tx_data,
    output logic              aux_tx_valid,
    output logic [BYTE_W-1:0] aux_tx_data,
    output logic              irq_kbd,
    output logic              irq_aux,
    output logic [BYTE_W-1:0] outport,
    output logic              sys_reset_req
);

    // Register state
    logic [BYTE_W-1:0] cfg_q;
    logic [BYTE_W-1:0] oport_q;
    logic [BYTE_W-1:0] obuf_data_q;
    logic              obf_q;
    logic              obuf_aux_q;
    logic              cmd_flag_q;
    pend_t             pend_q;
    logic              irq_kbd_q;
    logic              irq_aux_q;
    logic              sys_rst_q;
    logic              kbd_tx_valid_q;
    logic              aux_tx_valid_q;
    logic [BYTE_W-1:0] kbd_tx_data_q;
    logic [BYTE_W-1:0] aux_tx_data_q;

    // Receive queue bundle, indexed by port
    logic [NPORT-1:0]  rx_in_valid;
    logic [NPORT-1:0]  rx_in_ready;
    logic [BYTE_W-1:0] rx_in_data  [NPORT];
    logic [NPORT-1:0]  rx_out_valid;
    logic [BYTE_W-1:0] rx_out_data [NPORT];
    logic [NPORT-1:0]  rx_pop;
    logic [NPORT-1:0]  rx_off;

    // Decoded host activity
    cmd_dec_t          dec;
    logic              wr_cmd_en;
    logic              wr_data_en;
    logic              rd_data_en;
    logic              inject_en;
    logic              oport_wr_en;
    logic              load_en;
    logic [BYTE_W-1:0] load_byte;
    src_t              load_src;
    logic [BYTE_W-1:0] status;

    assign rx_in_valid[PORT_KBD] = kbd_in_valid;
    assign rx_in_valid[PORT_AUX] = aux_in_valid;
    assign rx_in_data[PORT_KBD]  = kbd_in_data;
    assign rx_in_data[PORT_AUX]  = aux_in_data;
    assign kbd_in_ready          = rx_in_ready[PORT_KBD];
    assign aux_in_ready          = rx_in_ready[PORT_AUX];
    assign rx_off[PORT_KBD]      = cfg_q[CFG_KBD_OFF];
    assign rx_off[PORT_AUX]      = cfg_q[CFG_AUX_OFF];

    // One receive queue per device port.
    for (genvar p = 0; p < NPORT; p++) begin : g_rx
        ps2h_rx_fifo #(
            .DW    (BYTE_W),
            .DEPTH (FIFO_DEPTH)
        ) u_fifo (
            .clk       (clk),
            .rst_n     (rst_n),
            .in_valid  (rx_in_valid[p]),
            .in_data   (rx_in_data[p]),
            .in_ready  (rx_in_ready[p]),
            .out_valid (rx_out_valid[p]),
            .out_data  (rx_out_data[p]),
            .out_ready (rx_pop[p])
        );
    end

    ps2h_refill_arb #(
        .NSRC (NPORT)
    ) u_arb (
        .buf_empty (!obf_q),
        .hold      (host_wr || host_rd),
        .src_valid (rx_out_valid),
        .src_off   (rx_off),
        .pop       (rx_pop)
    );

    ps2h_cmd_decode u_dec (
        .cmd   (host_wdata),
        .cfg   (cfg_q),
        .oport (oport_q),
        .dec   (dec)
    );

    // Classify the host access of this cycle.
    always_comb begin
        wr_cmd_en   = host_wr && host_addr;
        wr_data_en  = host_wr && !host_addr;
        rd_data_en  = host_rd && !host_addr;
        inject_en   = wr_data_en && ((pend_q == PEND_KBD_INJ) || (pend_q == PEND_AUX_INJ));
        oport_wr_en = wr_data_en && (pend_q == PEND_OPORT);
    end

    // Choose what, if anything, enters the output buffer this cycle.
    always_comb begin
        load_en   = 1'b0;
        load_byte = '0;
        load_src  = SRC_CTRL;
        if (wr_cmd_en && dec.resp_en) begin
            load_en   = 1'b1;
            load_byte = dec.resp_byte;
            load_src  = SRC_CTRL;
        end else if (inject_en) begin
            load_en   = 1'b1;
            load_byte = host_wdata;
            load_src  = (pend_q == PEND_AUX_INJ) ? SRC_AUX : SRC_KBD;
        end else if (rx_pop[PORT_KBD]) begin
            load_en   = 1'b1;
            load_byte = rx_out_data[PORT_KBD];
            load_src  = SRC_KBD;
        end else if (rx_pop[PORT_AUX]) begin
            load_en   = 1'b1;
            load_byte = rx_out_data[PORT_AUX];
            load_src  = SRC_AUX;
        end
    end

    // Output buffer, interrupt lines and output port.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            obf_q       <= 1'b0;
            obuf_data_q <= '0;
            obuf_aux_q  <= 1'b0;
            irq_kbd_q   <= 1'b0;
            irq_aux_q   <= 1'b0;
            oport_q     <= OPORT_RST;
        end else begin
            if (rd_data_en) begin
                obf_q                <= 1'b0;
                obuf_data_q          <= '0;
                obuf_aux_q           <= 1'b0;
                irq_kbd_q            <= 1'b0;
                irq_aux_q            <= 1'b0;
                oport_q[OP_KBD_IRQ]  <= 1'b0;
                oport_q[OP_AUX_IRQ]  <= 1'b0;
            end
            if (load_en) begin
                obf_q       <= 1'b1;
                obuf_data_q <= load_byte;
                obuf_aux_q  <= (load_src == SRC_AUX);
                if (load_src == SRC_KBD && cfg_q[CFG_KBD_IRQ]) begin
                    irq_kbd_q           <= 1'b1;
                    oport_q[OP_KBD_IRQ] <= 1'b1;
                end
                if (load_src == SRC_AUX && cfg_q[CFG_AUX_IRQ]) begin
                    irq_aux_q           <= 1'b1;
                    oport_q[OP_AUX_IRQ] <= 1'b1;
                end
            end
            if (oport_wr_en) begin
                oport_q   <= host_wdata;
                irq_kbd_q <= host_wdata[OP_KBD_IRQ];
                irq_aux_q <= host_wdata[OP_AUX_IRQ];
            end
        end
    end

    // Configuration, command flag, awaited argument and reset pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q      <= CFG_RST;
            cmd_flag_q <= 1'b0;
            pend_q     <= PEND_NONE;
            sys_rst_q  <= 1'b0;
        end else begin
            sys_rst_q <= 1'b0;
            if (wr_cmd_en) begin
                cmd_flag_q <= 1'b1;
                cfg_q      <= (cfg_q | dec.cfg_set) & ~dec.cfg_clr;
                pend_q     <= dec.pend;
                sys_rst_q  <= dec.reset_pulse;
            end
            if (wr_data_en) begin
                cmd_flag_q <= 1'b0;
                pend_q     <= PEND_NONE;
                if (pend_q == PEND_CFG) begin
                    cfg_q <= host_wdata;
                end
            end
        end
    end

    // Transmit strobes toward the two devices.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            kbd_tx_valid_q <= 1'b0;
            aux_tx_valid_q <= 1'b0;
            kbd_tx_data_q  <= '0;
            aux_tx_data_q  <= '0;
        end else begin
            kbd_tx_valid_q <= 1'b0;
            aux_tx_valid_q <= 1'b0;
            if (wr_data_en && pend_q == PEND_NONE) begin
                kbd_tx_valid_q <= 1'b1;
                kbd_tx_data_q  <= host_wdata;
            end
            if (wr_data_en && pend_q == PEND_AUX_TX) begin
                aux_tx_valid_q <= 1'b1;
                aux_tx_data_q  <= host_wdata;
            end
        end
    end

    // Status byte assembly.
    always_comb begin
        status           = '0;
        status[ST_FULL]  = obf_q;
        status[ST_SYS]   = cfg_q[CFG_SYS];
        status[ST_CMD]   = cmd_flag_q;
        status[ST_UNLCK] = 1'b1;
        status[ST_AUX]   = obuf_aux_q;
    end

    assign host_rdata    = host_addr ? status : obuf_data_q;
    assign irq_kbd       = irq_kbd_q;
    assign irq_aux       = irq_aux_q;
    assign outport       = oport_q;
    assign sys_reset_req = sys_rst_q;
    assign kbd_tx_valid  = kbd_tx_valid_q;
    assign kbd_tx_data   = kbd_tx_data_q;
    assign aux_tx_valid  = aux_tx_valid_q;
    assign aux_tx_data   = aux_tx_data_q;

endmodule

// File: rtl/ps2h_ctrl_chk.sv
// Temporal checks on the PS/2 host controller, attached by bind.
module ps2h_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       host_wr,
    input logic       host_rd,
    input logic       host_addr,
    input logic [7:0] host_wdata,
    input logic       irq_kbd,
    input logic       irq_aux,
    input logic [7:0] outport,
    input logic       sys_reset_req,
    input logic       aux_tx_valid,
    input logic       obf,
    input logic       obuf_aux,
    input logic       kbd_q_valid,
    input logic       kbd_off
);

    // R9
    irq_mirror_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (outport[4] == irq_kbd) && (outport[5] == irq_aux));

    // R10
    read_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd && !host_addr) |=> (!obf && !irq_kbd && !irq_aux && !obuf_aux));

    // R11
    kbd_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!obf && kbd_q_valid && !kbd_off && !host_wr && !host_rd) |=> (obf && !obuf_aux));

    // R12
    reset_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sys_reset_req |-> $past(host_wr && host_addr && host_wdata[7:4] == 4'hF && !host_wdata[0]));

    // R8
    aux_tx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        aux_tx_valid |-> $past(host_wr && !host_addr));

endmodule

bind ps2h_ctrl ps2h_ctrl_chk u_ps2h_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .host_wr       (host_wr),
    .host_rd       (host_rd),
    .host_addr     (host_addr),
    .host_wdata    (host_wdata),
    .irq_kbd       (irq_kbd),
    .irq_aux       (irq_aux),
    .outport       (outport),
    .sys_reset_req (sys_reset_req),
    .aux_tx_valid  (aux_tx_valid),
    .obf           (obf_q),
    .obuf_aux      (obuf_aux_q),
    .kbd_q_valid   (rx_out_valid[0]),
    .kbd_off       (cfg_q[4])
);

// File: tb/test_ps2h_ctrl.sv
// Bench for ps2h_ctrl: a vector table walked by one loop, then directed tests.
module test_ps2h_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 64;

    // Vector op codes
    localparam logic [3:0] OP_WRC  = 4'd0; // write command address
    localparam logic [3:0] OP_WRD  = 4'd1; // write data address
    localparam logic [3:0] OP_RDS  = 4'd2; // read status, compare
    localparam logic [3:0] OP_RDD  = 4'd3; // read data, compare
    localparam logic [3:0] OP_PK   = 4'd4; // push keyboard byte
    localparam logic [3:0] OP_PA   = 4'd5; // push aux byte
    localparam logic [3:0] OP_CIRQ = 4'd6; // compare {irq_aux, irq_kbd}
    localparam logic [3:0] OP_COP  = 4'd7; // compare output port
    localparam logic [3:0] OP_CTXK = 4'd8; // compare last keyboard tx byte

    // {op[31:28], data[27:20], expected[19:12], requirement[11:0]}
    localparam logic [31:0] VEC [64] = '{
        {OP_RDS,  8'h00, 8'h14, 12'd1},  // R1 status after reset
        {OP_CIRQ, 8'h00, 8'h00, 12'd1},  // R1 interrupts low
        {OP_COP,  8'h00, 8'h01, 12'd1},  // R1 output port
        {OP_WRC,  8'h20, 8'h00, 12'd0},
        {OP_RDS,  8'h00, 8'h1D, 12'd2},  // R2 full, cmd flag
        {OP_RDD,  8'h00, 8'h74, 12'd3},  // R3 config reply
        {OP_RDS,  8'h00, 8'h1C, 12'd2},  // R2 empty
        {OP_PK,   8'h1C, 8'h00, 12'd0},
        {OP_RDS,  8'h00, 8'h1C, 12'd11}, // R11 keyboard disabled, skipped
        {OP_WRC,  8'h60, 8'h00, 12'd0},
        {OP_WRD,  8'h07, 8'h00, 12'd0},
        {OP_RDS,  8'h00, 8'h15, 12'd11}, // R11 refill once enabled
        {OP_CIRQ, 8'h00, 8'h01, 12'd9},  // R9 keyboard irq
        {OP_COP,  8'h00, 8'h11, 12'd9},  // R9 mirror bit 4
        {OP_RDD,  8'h00, 8'h1C, 12'd10}, // R10 byte returned
        {OP_CIRQ, 8'h00, 8'h00, 12'd10}, // R10 irq cleared
        {OP_COP,  8'h00, 8'h01, 12'd10}, // R10 mirror cleared
        {OP_WRC,  8'h20, 8'h00, 12'd0},
        {OP_PA,   8'hA5, 8'h00, 12'd0},
        {OP_PK,   8'h3C, 8'h00, 12'd0},
        {OP_RDD,  8'h00, 8'h07, 12'd3},  // R3 config after load
        {OP_RDD,  8'h00, 8'h3C, 12'd11}, // R11 keyboard first
        {OP_RDS,  8'h00, 8'h3D, 12'd2},  // R2 aux source bit
        {OP_CIRQ, 8'h00, 8'h02, 12'd9},  // R9 aux irq
        {OP_COP,  8'h00, 8'h21, 12'd9},  // R9 mirror bit 5
        {OP_RDD,  8'h00, 8'hA5, 12'd11}, // R11 aux afterwards
        {OP_RDS,  8'h00, 8'h1C, 12'd10}, // R10 empty, bit 5 cleared
        {OP_WRC,  8'hAA, 8'h00, 12'd0},
        {OP_CIRQ, 8'h00, 8'h00, 12'd3},  // R3 reply raises no irq
        {OP_RDD,  8'h00, 8'h55, 12'd5},  // R5
        {OP_WRC,  8'hA9, 8'h00, 12'd0},
        {OP_RDS,  8'h00, 8'h1D, 12'd5},  // R5 reply present
        {OP_RDD,  8'h00, 8'h00, 12'd5},  // R5
        {OP_WRC,  8'hA1, 8'h00, 12'd0},
        {OP_RDD,  8'h00, 8'hF1, 12'd5},  // R5
        {OP_WRC,  8'hAD, 8'h00, 12'd0},
        {OP_WRC,  8'h20, 8'h00, 12'd0},
        {OP_RDD,  8'h00, 8'h17, 12'd4},  // R4 keyboard off
        {OP_WRC,  8'hAE, 8'h00, 12'd0},
        {OP_WRC,  8'hA7, 8'h00, 12'd0},
        {OP_WRC,  8'h20, 8'h00, 12'd0},
        {OP_RDD,  8'h00, 8'h27, 12'd4},  // R4 keyboard on, aux off
        {OP_WRC,  8'hA8, 8'h00, 12'd0},
        {OP_WRC,  8'h20, 8'h00, 12'd0},
        {OP_RDD,  8'h00, 8'h07, 12'd4},  // R4 aux on
        {OP_WRC,  8'hD1, 8'h00, 12'd0},
        {OP_WRD,  8'h33, 8'h00, 12'd0},
        {OP_COP,  8'h00, 8'h33, 12'd6},  // R6 output port loaded
        {OP_CIRQ, 8'h00, 8'h03, 12'd6},  // R6 irq lines follow
        {OP_WRC,  8'hD0, 8'h00, 12'd0},
        {OP_RDD,  8'h00, 8'h33, 12'd6},  // R6 output port reply
        {OP_COP,  8'h00, 8'h03, 12'd6},  // R6 bits 4,5 cleared by read
        {OP_WRC,  8'hD3, 8'h00, 12'd0},
        {OP_WRD,  8'h5A, 8'h00, 12'd0},
        {OP_RDS,  8'h00, 8'h35, 12'd7},  // R7 aux tagged
        {OP_CIRQ, 8'h00, 8'h02, 12'd7},  // R7 aux irq
        {OP_RDD,  8'h00, 8'h5A, 12'd7},  // R7
        {OP_WRC,  8'hD2, 8'h00, 12'd0},
        {OP_WRD,  8'h6B, 8'h00, 12'd0},
        {OP_CIRQ, 8'h00, 8'h01, 12'd7},  // R7 keyboard irq
        {OP_RDD,  8'h00, 8'h6B, 12'd7},  // R7
        {OP_WRD,  8'hF4, 8'h00, 12'd0},
        {OP_CTXK, 8'h00, 8'hF4, 12'd8},  // R8 keyboard forward
        {OP_RDS,  8'h00, 8'h14, 12'd2}   // R2 data write clears flag
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       host_wr = 1'b0;
    logic       host_rd = 1'b0;
    logic       host_addr = 1'b0;
    logic [7:0] host_wdata = '0;
    logic [7:0] host_rdata;
    logic       kbd_in_valid = 1'b0;
    logic [7:0] kbd_in_data = '0;
    logic       kbd_in_ready;
    logic       aux_in_valid = 1'b0;
    logic [7:0] aux_in_data = '0;
    logic       aux_in_ready;
    logic       kbd_tx_valid;
    logic [7:0] kbd_tx_data;
    logic       aux_tx_valid;
    logic [7:0] aux_tx_data;
    logic       irq_kbd;
    logic       irq_aux;
    logic [7:0] outport;
    logic       sys_reset_req;

    int checks = 0;
    int failures = 0;
    logic [7:0] last_ktx = '0;
    logic [7:0] last_atx = '0;
    int atx_count = 0;
    int rst_cycles = 0;
    logic done = 1'b0;

    ps2h_ctrl #(.FIFO_DEPTH(DEPTH)) i_ps2h_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .host_wr       (host_wr),
        .host_rd       (host_rd),
        .host_addr     (host_addr),
        .host_wdata    (host_wdata),
        .host_rdata    (host_rdata),
        .kbd_in_valid  (kbd_in_valid),
        .kbd_in_data   (kbd_in_data),
        .kbd_in_ready  (kbd_in_ready),
        .aux_in_valid  (aux_in_valid),
        .aux_in_data   (aux_in_data),
        .aux_in_ready  (aux_in_ready),
        .kbd_tx_valid  (kbd_tx_valid),
        .kbd_tx_data   (kbd_tx_data),
        .aux_tx_valid  (aux_tx_valid),
        .aux_tx_data   (aux_tx_data),
        .irq_kbd       (irq_kbd),
        .irq_aux       (irq_aux),
        .outport       (outport),
        .sys_reset_req (sys_reset_req)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    // Record transmit bytes and reset-pulse cycles.
    always @(posedge clk) begin
        if (kbd_tx_valid) last_ktx <= kbd_tx_data;
        if (aux_tx_valid) begin
            last_atx  <= aux_tx_data;
            atx_count <= atx_count + 1;
        end
        if (sys_reset_req) rst_cycles <= rst_cycles + 1;
    end

    task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic a, input logic [7:0] d);
        @(negedge clk);
        host_wr = 1'b1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic rd(input logic a, output logic [7:0] d);
        @(negedge clk);
        host_rd = 1'b1; host_addr = a;
        #1 d = host_rdata;
        @(negedge clk);
        host_rd = 1'b0;
    endtask

    task automatic push(input logic to_aux, input logic [7:0] d);
        @(negedge clk);
        if (to_aux) begin aux_in_valid = 1'b1; aux_in_data = d; end
        else begin kbd_in_valid = 1'b1; kbd_in_data = d; end
        @(negedge clk);
        aux_in_valid = 1'b0;
        kbd_in_valid = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        do_reset();

        // Table walk
        for (int i = 0; i < 64; i++) begin
            logic [3:0] op;
            logic [7:0] dat;
            logic [7:0] exp;
            string tag;
            op  = VEC[i][31:28];
            dat = VEC[i][27:20];
            exp = VEC[i][19:12];
            tag = $sformatf("R%0d vec%0d", VEC[i][11:0], i);
            case (op)
                OP_WRC:  wr(1'b1, dat);
                OP_WRD:  wr(1'b0, dat);
                OP_RDS:  begin rd(1'b1, v); chk(v, exp, tag); end
                OP_RDD:  begin rd(1'b0, v); chk(v, exp, tag); end
                OP_PK:   push(1'b0, dat);
                OP_PA:   push(1'b1, dat);
                OP_CIRQ: begin @(negedge clk); chk({6'd0, irq_aux, irq_kbd}, exp, tag); end
                OP_COP:  begin @(negedge clk); chk(outport, exp, tag); end
                OP_CTXK: begin @(negedge clk); chk(last_ktx, exp, tag); end
                default: ;
            endcase
        end

        // R8 forward to aux device
        wr(1'b1, 8'hD4);
        wr(1'b0, 8'hE8);
        @(negedge clk);
        chk(last_atx, 8'hE8, "R8 aux forward byte");
        chk(8'(atx_count), 8'd1, "R8 aux strobe count");
        chk(last_ktx, 8'hF4, "R8 keyboard untouched");

        // R3 pending config load cancelled by another command
        wr(1'b1, 8'h60);
        wr(1'b1, 8'hAA);
        rd(1'b0, v); chk(v, 8'h55, "R3 reply between");
        wr(1'b0, 8'h99);
        @(negedge clk);
        chk(last_ktx, 8'h99, "R3 cancelled load goes to keyboard");
        wr(1'b1, 8'h20);
        rd(1'b0, v); chk(v, 8'h07, "R3 config unchanged");

        // R12 reset pulses
        wr(1'b1, 8'hF1);
        @(negedge clk);
        chk(8'(rst_cycles), 8'd0, "R12 odd command no pulse");
        wr(1'b1, 8'hFE);
        @(negedge clk);
        chk(8'(rst_cycles), 8'd1, "R12 FE one-cycle pulse");
        wr(1'b1, 8'hF0);
        @(negedge clk);
        chk(8'(rst_cycles), 8'd2, "R12 F0 one-cycle pulse");
        wr(1'b1, 8'hF7);
        wr(1'b1, 8'h20);
        rd(1'b0, v); chk(v, 8'h07, "R12 odd command leaves config");

        // R9 gating: interrupts disabled in config
        wr(1'b1, 8'h60);
        wr(1'b0, 8'h04);
        push(1'b0, 8'h11);
        @(negedge clk);
        chk({6'd0, irq_aux, irq_kbd}, 8'h00, "R9 gated irq stays low");
        rd(1'b1, v); chk(v, 8'h15, "R9 byte buffered");
        rd(1'b0, v); chk(v, 8'h11, "R9 byte value");

        // R10 empty read
        rd(1'b0, v); chk(v, 8'h00, "R10 empty read");

        // R13 fill keyboard queue while disabled, then drain in order
        wr(1'b1, 8'hAD);
        for (int k = 0; k < DEPTH; k++) begin
            if (!kbd_in_ready) begin
                checks++; failures++;
                $display("FAIL R13 ready low early at %0d actual=0 expected=1", k);
            end
            push(1'b0, 8'(k + 8'h40));
        end
        @(negedge clk);
        chk({7'd0, kbd_in_ready}, 8'h00, "R13 ready low when full");
        wr(1'b1, 8'hAE);
        for (int k = 0; k < DEPTH; k++) begin
            rd(1'b0, v);
            chk(v, 8'(k + 8'h40), "R13 drain order");
        end
        @(negedge clk);
        chk({7'd0, kbd_in_ready}, 8'h01, "R13 ready after drain");

        // R1 reset mid-run
        wr(1'b1, 8'hAD);
        wr(1'b1, 8'hD1);
        wr(1'b0, 8'h30);
        do_reset();
        rd(1'b1, v); chk(v, 8'h14, "R1 status after second reset");
        chk(outport, 8'h01, "R1 output port after second reset");
        chk({6'd0, irq_aux, irq_kbd}, 8'h00, "R1 irqs after second reset");
        wr(1'b1, 8'h20);
        rd(1'b0, v); chk(v, 8'h74, "R1 config after second reset");

        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule